// File: doc/BRIEF.md
# Branch Target and Program Counter Unit

This unit keeps the instruction pointer and the code segment pointer of a segmented 16-bit controller. On each clock it either moves the instruction pointer past the instruction now executing, or it loads a branch target. The execute stage supplies that target through a strobe, a mode code and the operand fields. The unit has five target modes:

- a plain 16-bit address inside the current segment
- a signed word displacement measured from the next instruction
- a register value used as is
- a new segment together with an address
- a vector number that selects a double-word slot in segment 0

Any even target is taken. An odd target taken from an address operand or a register is refused. In that case both pointers keep their values and the unit raises a one-cycle trap request, which a separate trap sequencer acts on. The parameter `NUM_SEGS` (4 or 256) sets how many bits of the segment operand are kept.

All outputs are registered. A strobe sampled at one rising edge takes effect at that same edge, so its result is visible during the following cycle.

Top module: `branch_pc_unit`

## Requirements
- R1: While `rst_n` is low, `ip_o` and `csp_o` are zero and `trap_req_o` is low.
- R2: With `br_valid` low, `ip_o` grows by 2 when `ins_dword`=0 (one-word instruction) or by 4 when `ins_dword`=1 (two-word instruction), modulo 2^16, and `csp_o` holds.
- R3: Mode code 0 (absolute) with an even `op_addr` loads `ip_o` with `op_addr` and leaves `csp_o` unchanged.
- R4: In modes 0, 2 or 3, a target whose bit 0 is 1 is not taken. `ip_o` and `csp_o` keep their values, and `trap_req_o` is high during the next cycle.
- R5: Mode code 1 (relative) loads `ip_o` with (current `ip_o` + instruction length in bytes + 2 × `op_rel` read as 8-bit two's complement) modulo 2^16, and `csp_o` holds.
- R6: A relative branch with `op_rel`=FFh on a one-word instruction, or with `op_rel`=FEh on a two-word instruction, leaves `ip_o` equal to its own address.
- R7: Mode code 2 (indirect) with an even `reg_val` loads `ip_o` with `reg_val` unchanged and keeps `csp_o`.
- R8: Mode code 3 (segment) with an even `op_addr` loads `ip_o` with `op_addr` and loads `csp_o` with the low log2(`NUM_SEGS`) bits of `op_seg`.
- R9: Mode code 4 (vector) clears `csp_o` and loads `ip_o` with `op_trap` × 4. `op_trap` is 7 bits wide, so the target lies between 0000h and 01FCh.
- R10: Mode codes 5 to 7 with `br_valid` high act exactly like a cycle with no branch.
- R11: `trap_req_o` is high only in the cycle that follows a refused odd target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is taken this cycle |
| br_mode | input | 3 | Target mode: 0 absolute, 1 relative, 2 indirect, 3 segment, 4 vector |
| ins_dword | input | 1 | Current instruction is two words long |
| op_addr | input | 16 | Absolute address operand |
| op_rel | input | 8 | Signed word displacement |
| op_seg | input | 8 | Segment operand |
| op_trap | input | 7 | Vector number |
| reg_val | input | 16 | Word register value for indirect branches |
| ip_o | output | 16 | Instruction pointer |
| csp_o | output | log2(NUM_SEGS) | Code segment pointer |
| trap_req_o | output | 1 | Odd-target trap request pulse |

## Verification
Every result (the new `ip_o`, the new `csp_o` and the trap pulse) is due exactly one cycle after the strobe that caused it, because each one passes through a single register stage.

The bench drives each set of inputs on a falling edge and advances its reference model for that cycle. It then compares all three outputs at the next falling edge, half a period after the register has updated. The trap pulse is also checked in the cycle that follows it, to confirm that it falls again.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int ADDR_W    = 16;
  localparam int OFS_W     = 8;
  localparam int SEG_OPW   = 8;
  localparam int TRAPNUM_W = 7;

  typedef enum logic [2:0] {
    BR_ABS = 3'd0,
    BR_REL = 3'd1,
    BR_IND = 3'd2,
    BR_SEG = 3'd3,
    BR_VEC = 3'd4
  } br_mode_e;

  typedef enum logic [1:0] {
    CSP_HOLD  = 2'd0,
    CSP_LOAD  = 2'd1,
    CSP_CLEAR = 2'd2
  } csp_op_e;

  // address of the instruction after the current one
  function automatic logic [ADDR_W-1:0] f_next_ip(input logic [ADDR_W-1:0] ip,
                                                   input logic dword);
    return ip + (dword ? ADDR_W'(4) : ADDR_W'(2));
  endfunction

  // word displacement scaled to bytes, sign extended, wraps in segment
  function automatic logic [ADDR_W-1:0] f_rel_target(input logic [ADDR_W-1:0] nxt,
                                                      input logic [OFS_W-1:0] ofs);
    logic [ADDR_W-1:0] disp;
    disp = {{(ADDR_W-OFS_W-1){ofs[OFS_W-1]}}, ofs, 1'b0};
    return nxt + disp;
  endfunction

  // double-word vector slot
  function automatic logic [ADDR_W-1:0] f_vec_target(input logic [TRAPNUM_W-1:0] num);
    return {{(ADDR_W-TRAPNUM_W-2){1'b0}}, num, 2'b00};
  endfunction
endpackage

// File: rtl/bt_target_calc.sv
module bt_target_calc
  import bt_pkg::*;
(
  input  logic [ADDR_W-1:0]    ip_q,
  input  logic                 br_valid,
  input  logic [2:0]           br_mode,
  input  logic                 ins_dword,
  input  logic [ADDR_W-1:0]    op_addr,
  input  logic [OFS_W-1:0]     op_rel,
  input  logic [TRAPNUM_W-1:0] op_trap,
  input  logic [ADDR_W-1:0]    reg_val,
  output logic [ADDR_W-1:0]    ip_nxt,
  output csp_op_e              csp_op,
  output logic                 odd_fault
);
  logic [ADDR_W-1:0] seq_ip;
  logic [ADDR_W-1:0] cand;
  logic              cand_chk;
  br_mode_e          mode;

  assign mode   = br_mode_e'(br_mode);
  assign seq_ip = f_next_ip(ip_q, ins_dword);

  always_comb begin
    ip_nxt    = seq_ip;
    csp_op    = CSP_HOLD;
    cand      = '0;
    cand_chk  = 1'b0;
    odd_fault = 1'b0;
    if (br_valid) begin
      unique case (mode)
        BR_ABS: begin cand = op_addr; cand_chk = 1'b1; end
        BR_REL: ip_nxt = f_rel_target(seq_ip, op_rel);
        BR_IND: begin cand = reg_val; cand_chk = 1'b1; end
        BR_SEG: begin cand = op_addr; cand_chk = 1'b1; csp_op = CSP_LOAD; end
        BR_VEC: begin ip_nxt = f_vec_target(op_trap); csp_op = CSP_CLEAR; end
        default: ip_nxt = seq_ip;
      endcase
      if (cand_chk) begin
        if (cand[0]) begin
          odd_fault = 1'b1;
          ip_nxt    = ip_q;
          csp_op    = CSP_HOLD;
        end else begin
          ip_nxt = cand;
        end
      end
    end
  end
endmodule

// File: rtl/bt_seg_trim.sv
module bt_seg_trim
  import bt_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_OPW-1:0] seg_in,
  output logic [SEG_W-1:0]   seg_out
);
  generate
    if (SEG_W < SEG_OPW) begin : g_narrow
      assign seg_out = seg_in[SEG_W-1:0];
    end else if (SEG_W == SEG_OPW) begin : g_full
      assign seg_out = seg_in;
    end else begin : g_wide
      assign seg_out = {{(SEG_W-SEG_OPW){1'b0}}, seg_in};
    end
  endgenerate
endmodule

// File: rtl/bt_trap_pulse.sv
module bt_trap_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= fault;
  end
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import bt_pkg::*;
#(
  parameter int NUM_SEGS = 256,
  localparam int SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_valid,
  input  logic [2:0]           br_mode,
  input  logic                 ins_dword,
  input  logic [ADDR_W-1:0]    op_addr,
  input  logic [OFS_W-1:0]     op_rel,
  input  logic [SEG_OPW-1:0]   op_seg,
  input  logic [TRAPNUM_W-1:0] op_trap,
  input  logic [ADDR_W-1:0]    reg_val,
  output logic [ADDR_W-1:0]    ip_o,
  output logic [SEG_W-1:0]     csp_o,
  output logic                 trap_req_o
);
  logic [ADDR_W-1:0] ip_q;
  logic [ADDR_W-1:0] ip_nxt;
  logic [SEG_W-1:0]  csp_q;
  logic [SEG_W-1:0]  seg_trim;
  csp_op_e           csp_op;
  logic              odd_fault;

  bt_target_calc u_calc (
    .ip_q      (ip_q),
    .br_valid  (br_valid),
    .br_mode   (br_mode),
    .ins_dword (ins_dword),
    .op_addr   (op_addr),
    .op_rel    (op_rel),
    .op_trap   (op_trap),
    .reg_val   (reg_val),
    .ip_nxt    (ip_nxt),
    .csp_op    (csp_op),
    .odd_fault (odd_fault)
  );

  bt_seg_trim #(.SEG_W(SEG_W)) u_trim (
    .seg_in  (op_seg),
    .seg_out (seg_trim)
  );

  bt_trap_pulse u_trap (
    .clk   (clk),
    .rst_n (rst_n),
    .fault (odd_fault),
    .req   (trap_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= '0;
    else        ip_q <= ip_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csp_q <= '0;
    end else begin
      unique case (csp_op)
        CSP_LOAD:  csp_q <= seg_trim;
        CSP_CLEAR: csp_q <= '0;
        default:   csp_q <= csp_q;
      endcase
    end
  end

  assign ip_o  = ip_q;
  assign csp_o = csp_q;
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int SEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [2:0]       br_mode,
  input logic             ins_dword,
  input logic [15:0]      op_addr,
  input logic [7:0]       op_rel,
  input logic [7:0]       op_seg,
  input logic [15:0]      reg_val,
  input logic [15:0]      ip_o,
  input logic [SEG_W-1:0] csp_o,
  input logic             trap_req_o,
  input logic             odd_fault
);
  logic seq_cycle;
  assign seq_cycle = !br_valid || (br_mode > 3'd4);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid) |=> (ip_o == $past(ip_o) + ($past(ins_dword) ? 16'd4 : 16'd2)) && $stable(csp_o));

  p_absolute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mode == 3'd0 && !op_addr[0]) |=> (ip_o == $past(op_addr)) && $stable(csp_o));

  p_odd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    odd_fault |=> trap_req_o && $stable(ip_o) && $stable(csp_o));

  p_self_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mode == 3'd1 &&
     ((!ins_dword && op_rel == 8'hFF) || (ins_dword && op_rel == 8'hFE))) |=> $stable(ip_o));

  p_indirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mode == 3'd2 && !reg_val[0]) |=> (ip_o == $past(reg_val)) && $stable(csp_o));

  p_segment_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mode == 3'd3 && !op_addr[0]) |=> (csp_o == $past(op_seg[SEG_W-1:0])));

  p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mode == 3'd4) |=> (csp_o == '0) && (ip_o[15:9] == 7'd0) && (ip_o[1:0] == 2'd0));

  p_spare_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mode > 3'd4) |=> (ip_o == $past(ip_o) + ($past(ins_dword) ? 16'd4 : 16'd2)) && !trap_req_o);

  p_trap_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> $past(odd_fault));

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_cycle |=> !trap_req_o);
endmodule

bind branch_pc_unit bt_checker #(.SEG_W(SEG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .br_valid   (br_valid),
  .br_mode    (br_mode),
  .ins_dword  (ins_dword),
  .op_addr    (op_addr),
  .op_rel     (op_rel),
  .op_seg     (op_seg),
  .reg_val    (reg_val),
  .ip_o       (ip_o),
  .csp_o      (csp_o),
  .trap_req_o (trap_req_o),
  .odd_fault  (odd_fault)
);

// File: tb/branch_pc_unit_tb.sv
module branch_pc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG       = 256;
  localparam int SW         = $clog2(NSEG);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [2:0]  br_mode = '0;
  logic        ins_dword = 1'b0;
  logic [15:0] op_addr = '0;
  logic [7:0]  op_rel = '0;
  logic [7:0]  op_seg = '0;
  logic [6:0]  op_trap = '0;
  logic [15:0] reg_val = '0;
  logic [15:0] ip_o;
  logic [SW-1:0] csp_o;
  logic        trap_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ip = 0;
  int m_csp = 0;
  int m_trap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_pc_unit #(.NUM_SEGS(NSEG)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_mode(br_mode),
    .ins_dword(ins_dword), .op_addr(op_addr), .op_rel(op_rel), .op_seg(op_seg),
    .op_trap(op_trap), .reg_val(reg_val), .ip_o(ip_o), .csp_o(csp_o),
    .trap_req_o(trap_req_o)
  );

  task automatic compare(input string tag);
    checks++;
    if (int'(ip_o) != m_ip || int'(csp_o) != m_csp || int'(trap_req_o) != m_trap) begin
      errors++;
      $display("FAIL %s: ip=%h csp=%h trap=%0d expected ip=%h csp=%h trap=%0d",
               tag, ip_o, csp_o, trap_req_o, m_ip[15:0], m_csp, m_trap);
    end
  endtask

  // behavioural reference for one cycle
  task automatic model(input bit v, input int mode, input bit dw, input int addr,
                       input int rel, input int seg, input int trp, input int rv);
    int nxt, disp, tgt;
    bit odd;
    odd  = 0;
    nxt  = (m_ip + (dw ? 4 : 2)) % 65536;
    tgt  = nxt;
    if (v) begin
      case (mode)
        0: begin if (addr % 2 == 1) odd = 1; else tgt = addr; end
        1: begin
             disp = (rel >= 128) ? rel - 256 : rel;
             tgt = (nxt + 2 * disp + 65536) % 65536;
           end
        2: begin if (rv % 2 == 1) odd = 1; else tgt = rv; end
        3: begin
             if (addr % 2 == 1) odd = 1;
             else begin tgt = addr; m_csp = seg % NSEG; end
           end
        4: begin tgt = trp * 4; m_csp = 0; end
        default: tgt = nxt;
      endcase
    end
    if (odd) tgt = m_ip;
    m_ip   = tgt;
    m_trap = odd;
  endtask

  task automatic step(input bit v, input int mode, input bit dw, input int addr,
                      input int rel, input int seg, input int trp, input int rv,
                      input string tag);
    br_valid  = v;
    br_mode   = 3'(mode);
    ins_dword = dw;
    op_addr   = 16'(addr);
    op_rel    = 8'(rel);
    op_seg    = 8'(seg);
    op_trap   = 7'(trp);
    reg_val   = 16'(rv);
    model(v, mode, dw, addr, rel, seg, trp, rv);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input bit dw, input string tag);
    step(0, 0, dw, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;

    // R2 sequential advance
    idle(0, "R2 one-word");
    idle(1, "R2 two-word");
    idle(0, "R2 one-word again");

    // R3 absolute, then wrap of R2
    step(1, 0, 0, 16'h1234, 0, 0, 0, 0, "R3 absolute");
    step(1, 0, 0, 16'hFFFE, 0, 0, 0, 0, "R3 absolute high");
    idle(0, "R2 wrap to zero");
    step(1, 0, 1, 16'hFFFC, 0, 0, 0, 0, "R3 absolute two-word");
    idle(1, "R2 wrap two-word");

    // R4 odd absolute, then R11 pulse ends
    step(1, 0, 0, 16'h2001, 0, 0, 0, 0, "R4 odd absolute");
    idle(0, "R11 pulse ends");

    // R5 relative
    step(1, 0, 0, 16'h0400, 0, 0, 0, 0, "R3 set base");
    step(1, 1, 0, 0, 8'h7F, 0, 0, 0, "R5 forward max");
    step(1, 1, 1, 0, 8'h80, 0, 0, 0, "R5 backward max");
    step(1, 1, 0, 0, 8'h00, 0, 0, 0, "R5 zero offset");
    step(1, 1, 0, 0, 8'hFF, 0, 0, 0, "R6 self loop one-word");
    step(1, 1, 1, 0, 8'hFE, 0, 0, 0, "R6 self loop two-word");
    step(1, 0, 0, 16'h0010, 0, 0, 0, 0, "R3 low base");
    step(1, 1, 0, 0, 8'hF0, 0, 0, 0, "R5 wrap below zero");

    // R7 indirect
    step(1, 2, 0, 0, 0, 0, 0, 16'hBEEE, "R7 indirect");
    step(1, 2, 1, 0, 0, 0, 0, 16'h7777, "R4 odd indirect");
    idle(1, "R11 after odd indirect");

    // R8 segment
    step(1, 3, 1, 16'h4000, 0, 8'hA7, 0, 0, "R8 segment load");
    idle(0, "R2 csp held");
    step(1, 3, 0, 16'h4003, 0, 8'h11, 0, 0, "R4 odd segment");
    step(1, 3, 0, 16'h4005, 0, 8'h22, 0, 0, "R4 back-to-back odd");
    idle(0, "R11 after two odd");
    step(1, 3, 0, 16'h0100, 0, 8'hFF, 0, 0, "R8 segment max");
    step(1, 0, 0, 16'h0200, 0, 0, 0, 0, "R3 csp kept");

    // R9 vector
    step(1, 4, 0, 0, 0, 0, 7'h7F, 0, "R9 vector top");
    step(1, 3, 0, 16'h0800, 0, 8'h05, 0, 0, "R8 segment reload");
    step(1, 4, 1, 0, 0, 0, 7'h00, 0, "R9 vector zero");
    step(1, 4, 0, 0, 0, 0, 7'h2A, 0, "R9 vector mid");

    // R10 spare codes
    step(1, 5, 0, 16'h0001, 8'h10, 8'h33, 7'h01, 16'h0003, "R10 code 5");
    step(1, 6, 1, 16'h1000, 8'h80, 8'h33, 7'h01, 16'h1000, "R10 code 6");
    step(1, 7, 0, 16'h2000, 8'hFF, 8'h33, 7'h01, 16'h2000, "R10 code 7");

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int md, ad;
      md = $urandom_range(0, 7);
      ad = $urandom_range(0, 65535);
      step($urandom_range(0, 1) == 1, md, $urandom_range(0, 1) == 1, ad,
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 127),
           $urandom_range(0, 65535), "R11 mixed traffic");
    end

    // R1 mid-run reset
    rst_n = 1'b0;
    m_ip = 0; m_csp = 0; m_trap = 0;
    @(negedge clk);
    compare("R1 reset again");
    rst_n = 1'b1;
    idle(0, "R2 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule